// File: doc/BRIEF.md
# Interrupt Context Shadow Controller

This block sequences interrupt entry and return for a small 8-bit microcontroller core. It latches pending request flags from the interrupt sources and watches a global enable from software. When it accepts a request, it saves the program counter in a one-deep interrupt stack. This stack is kept apart from the subroutine call stack. The block also copies the working register, status, file-select and mode registers into shadow registers. It then tells the core to load the vector address, and it clears the page-select bits of STATUS.

All sources have equal priority, and there is no nesting. While a service routine runs, new requests only set their pending flags. The core signals the end of a routine with one of two return strobes. Both strobes make the block hand back the saved PC and all four shadows as load commands for the core. The second strobe also adds the current W to the real-time counter. The instruction decoder, the ALU and the call stack sit outside this block.

Top module: `irq_ctx_ctrl`

## Requirements
- R1: A set strobe on source i makes pending bit i read 1 after the next clock edge. The bit clears only on an edge where its clear strobe is high and its set strobe is low. When set and clear arrive in the same cycle, the bit ends up set.
- R2: An interrupt is accepted on an edge where the global enable is 1, `in_service_o` is 0 and at least one pending bit is 1. After that edge `in_service_o` reads 1. No interrupt is accepted while the global enable is 0.
- R3: One cycle after an acceptance edge, `pc_we_o` pulses high for one cycle with `pc_o` = 0 (the vector) and `ctx_we_o` = 0.
- R4: Acceptance captures `pc_i`, `w_i`, `status_i`, `fsr_i` and `mode_i`. The following return outputs exactly these values on `pc_o`, `w_o`, `status_o`, `fsr_o` and `mode_o`. Later changes to the inputs do not affect them.
- R5: In the entry pulse, `status_we_o` is 1 and `status_o` equals the sampled STATUS with bits 7:5 (the page-select bits) forced to 0. The shadow keeps the original bits 7:5.
- R6: While `in_service_o` is 1, no further acceptance happens and no `pc_we_o` pulse occurs until a return strobe.
- R7: A plain return (`ret_i`) while in service clears `in_service_o`. After the edge, it pulses `pc_we_o`, `ctx_we_o` and `status_we_o` with the saved values, and `rtcc_we_o` stays 0.
- R8: An add-W return (`retw_i`) does everything R7 does. It also pulses `rtcc_we_o` with `rtcc_o` = (`rtcc_i` + `w_i`) mod 256, where `w_i` is sampled at the return edge.
- R9: A return strobe while not in service is ignored. It produces no load pulse, and it leaves the saved context unchanged.
- R10: A request that becomes pending during a service routine is accepted on the edge right after the return edge, provided the global enable is 1.
- R11: After reset, all pending bits, `in_service_o` and every write-enable output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gie_i | input | 1 | Global interrupt enable from software |
| src_set_i | input | NSRC | Per-source request set strobes |
| src_clr_i | input | NSRC | Per-source software clear strobes |
| ret_i | input | 1 | Plain return-from-interrupt strobe |
| retw_i | input | 1 | Return strobe that also adds W to the counter |
| pc_i | input | PC_W | Current program counter |
| w_i | input | DW | Current W register |
| status_i | input | DW | Current STATUS register |
| fsr_i | input | DW | Current file-select register |
| mode_i | input | DW | Current MODE register |
| rtcc_i | input | DW | Current real-time counter value |
| pending_o | output | NSRC | Latched pending flags |
| in_service_o | output | 1 | Service routine active |
| pc_we_o | output | 1 | Load `pc_o` into the PC |
| pc_o | output | PC_W | Vector or restored PC |
| status_we_o | output | 1 | Load `status_o` into STATUS |
| status_o | output | DW | Page-cleared or restored STATUS |
| ctx_we_o | output | 1 | Load W, FSR and MODE from the outputs below |
| w_o | output | DW | Restored W |
| fsr_o | output | DW | Restored FSR |
| mode_o | output | DW | Restored MODE |
| rtcc_we_o | output | 1 | Load `rtcc_o` into the counter |
| rtcc_o | output | DW | Counter plus W, wrapped |

## Verification
A stuck or lost in-service state shows up at the ports within one cycle. It appears as a second vector load inside a routine, or as a missing entry one edge after a return with a flag still pending. A corrupted shadow or interrupt stack stays hidden until the next return. At that return the restored PC, STATUS, W, FSR or MODE differs from what was sampled at entry. The bench therefore pairs every entry with its return, and it checks that an ignored return leaves the saved context intact.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;
  localparam int DW = 8;
  localparam int PAGE_LSB = 5;

  typedef struct packed {
    logic [DW-1:0] w;
    logic [DW-1:0] status;
    logic [DW-1:0] fsr;
    logic [DW-1:0] mode;
  } ctx_t;

  // Drop the page-select field (top bits from PAGE_LSB upward).
  function automatic logic [DW-1:0] page_strip(input logic [DW-1:0] s);
    logic [DW-1:0] keep;
    keep = {{(DW-PAGE_LSB){1'b0}}, {PAGE_LSB{1'b1}}};
    return s & keep;
  endfunction

  // Counter plus W, truncated to the register width.
  function automatic logic [DW-1:0] timer_add(input logic [DW-1:0] t,
                                              input logic [DW-1:0] w);
    return t + w;
  endfunction
endpackage

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o
);
  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend_o[i] <= 1'b0;
      else if (set_i[i]) pend_o[i] <= 1'b1;
      else if (clr_i[i]) pend_o[i] <= 1'b0;
    end
  end

  assert_set_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((pend_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/irq_seq.sv
module irq_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic gie_i,
  input  logic any_pend_i,
  input  logic ret_i,
  input  logic retw_i,
  output logic take_o,
  output logic ret_go_o,
  output logic add_go_o,
  output logic busy_o
);
  assign take_o   = gie_i && !busy_o && any_pend_i;
  assign ret_go_o = busy_o && (ret_i || retw_i);
  assign add_go_o = busy_o && retw_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy_o <= 1'b0;
    else if (take_o)   busy_o <= 1'b1;
    else if (ret_go_o) busy_o <= 1'b0;
  end

  assert_entry_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> busy_o);
  assert_ret_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ret_go_o |=> !busy_o);
  assert_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie_i && !busy_o) |=> !busy_o);
endmodule

// File: rtl/irq_shadow_bank.sv
module irq_shadow_bank
  import irq_ctx_pkg::*;
#(
  parameter int PC_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_i,
  input  logic [PC_W-1:0] pc_i,
  input  ctx_t            ctx_i,
  output logic [PC_W-1:0] pc_o,
  output ctx_t            ctx_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_o  <= '0;
      ctx_o <= '0;
    end else if (cap_i) begin
      pc_o  <= pc_i;
      ctx_o <= ctx_i;
    end
  end

  assert_shadow_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> ($stable(pc_o) && $stable(ctx_o)));
endmodule

// File: rtl/irq_ctx_ctrl.sv
module irq_ctx_ctrl
  import irq_ctx_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int PC_W = 11,
  parameter logic [PC_W-1:0] VEC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gie_i,
  input  logic [NSRC-1:0] src_set_i,
  input  logic [NSRC-1:0] src_clr_i,
  input  logic            ret_i,
  input  logic            retw_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [DW-1:0]   w_i,
  input  logic [DW-1:0]   status_i,
  input  logic [DW-1:0]   fsr_i,
  input  logic [DW-1:0]   mode_i,
  input  logic [DW-1:0]   rtcc_i,
  output logic [NSRC-1:0] pending_o,
  output logic            in_service_o,
  output logic            pc_we_o,
  output logic [PC_W-1:0] pc_o,
  output logic            status_we_o,
  output logic [DW-1:0]   status_o,
  output logic            ctx_we_o,
  output logic [DW-1:0]   w_o,
  output logic [DW-1:0]   fsr_o,
  output logic [DW-1:0]   mode_o,
  output logic            rtcc_we_o,
  output logic [DW-1:0]   rtcc_o
);
  logic            take, ret_go, add_go;
  logic [PC_W-1:0] sh_pc;
  ctx_t            sh_ctx, live_ctx;

  assign live_ctx = '{w: w_i, status: status_i, fsr: fsr_i, mode: mode_i};

  irq_pend_latch #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(src_set_i), .clr_i(src_clr_i),
    .pend_o(pending_o));

  irq_seq u_seq (
    .clk(clk), .rst_n(rst_n), .gie_i(gie_i), .any_pend_i(|pending_o),
    .ret_i(ret_i), .retw_i(retw_i), .take_o(take), .ret_go_o(ret_go),
    .add_go_o(add_go), .busy_o(in_service_o));

  irq_shadow_bank #(.PC_W(PC_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .cap_i(take), .pc_i(pc_i), .ctx_i(live_ctx),
    .pc_o(sh_pc), .ctx_o(sh_ctx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_we_o     <= 1'b0;
      pc_o        <= '0;
      status_we_o <= 1'b0;
      status_o    <= '0;
      ctx_we_o    <= 1'b0;
      w_o         <= '0;
      fsr_o       <= '0;
      mode_o      <= '0;
      rtcc_we_o   <= 1'b0;
      rtcc_o      <= '0;
    end else begin
      pc_we_o     <= 1'b0;
      status_we_o <= 1'b0;
      ctx_we_o    <= 1'b0;
      rtcc_we_o   <= 1'b0;
      if (take) begin
        pc_we_o     <= 1'b1;
        pc_o        <= VEC;
        status_we_o <= 1'b1;
        status_o    <= page_strip(status_i);
      end else if (ret_go) begin
        pc_we_o     <= 1'b1;
        pc_o        <= sh_pc;
        status_we_o <= 1'b1;
        status_o    <= sh_ctx.status;
        ctx_we_o    <= 1'b1;
        w_o         <= sh_ctx.w;
        fsr_o       <= sh_ctx.fsr;
        mode_o      <= sh_ctx.mode;
        if (add_go) begin
          rtcc_we_o <= 1'b1;
          rtcc_o    <= timer_add(rtcc_i, w_i);
        end
      end
    end
  end

  assert_vector_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (pc_we_o && pc_o == VEC && !ctx_we_o));
  assert_page_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (status_o[DW-1:PAGE_LSB] == '0));
  assert_restore_pc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ret_go |=> (pc_o == $past(sh_pc) && ctx_we_o));
  assert_ignore_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((ret_i || retw_i) && !in_service_o) |=> !ctx_we_o);
  assert_no_nest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_service_o && !ret_i && !retw_i) |=> !pc_we_o);
  assert_add_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (retw_i && in_service_o) |=> rtcc_we_o);
endmodule

// File: tb/sim_irq_ctx_ctrl.sv
module sim_irq_ctx_ctrl;
  logic clk = 0, rst_n = 0, gie = 0, ret = 0, retw = 0;
  logic [7:0] set = 0, clr = 0;
  logic [10:0] pc = 0;
  logic [7:0] w = 0, st = 0, fsr = 0, mode = 0, rtcc = 0;
  logic [7:0] pend;
  logic in_svc, pc_we, st_we, ctx_we, rt_we;
  logic [10:0] pc_out;
  logic [7:0] st_out, w_out, fsr_out, mode_out, rt_out;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  irq_ctx_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .gie_i(gie), .src_set_i(set), .src_clr_i(clr),
    .ret_i(ret), .retw_i(retw), .pc_i(pc), .w_i(w), .status_i(st),
    .fsr_i(fsr), .mode_i(mode), .rtcc_i(rtcc), .pending_o(pend),
    .in_service_o(in_svc), .pc_we_o(pc_we), .pc_o(pc_out),
    .status_we_o(st_we), .status_o(st_out), .ctx_we_o(ctx_we), .w_o(w_out),
    .fsr_o(fsr_out), .mode_o(mode_out), .rtcc_we_o(rt_we), .rtcc_o(rt_out));

  typedef struct {
    bit is_ret; logic [10:0] pc; logic [7:0] w, st, fsr, mode; bit add; logic [7:0] rt;
  } exp_t;
  exp_t q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic exp_entry(input logic [7:0] s);
    exp_t e;
    e = '{is_ret: 0, pc: 0, w: 0, st: {3'b000, s[4:0]}, fsr: 0, mode: 0, add: 0, rt: 0};
    q.push_back(e);
  endtask

  task automatic exp_ret(input logic [10:0] p, input logic [7:0] ew, es, ef, em,
                         input bit a, input logic [7:0] r);
    exp_t e;
    e = '{is_ret: 1, pc: p, w: ew, st: es, fsr: ef, mode: em, add: a, rt: r};
    q.push_back(e);
  endtask

  // Monitor: every PC load must match the next expected event.
  always @(negedge clk) begin
    if (rst_n && pc_we) begin
      if (q.size() == 0) chk(0, "R6 R9 unexpected pc load", {21'b0, pc_out}, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        if (!e.is_ret) begin
          chk(pc_out == 0 && !ctx_we && !rt_we, "R3 vector load", {21'b0, pc_out}, 0);
          chk(st_we && st_out == e.st, "R5 page bits cleared", {24'b0, st_out}, {24'b0, e.st});
        end else begin
          chk(pc_out == e.pc, "R4 restored pc", {21'b0, pc_out}, {21'b0, e.pc});
          chk(ctx_we && st_we && w_out == e.w && st_out == e.st && fsr_out == e.fsr && mode_out == e.mode,
              "R4 R7 restored context", {w_out, st_out, fsr_out, mode_out}, {e.w, e.st, e.fsr, e.mode});
          chk(rt_we == e.add, "R8 counter write enable", {31'b0, rt_we}, {31'b0, e.add});
          if (e.add) chk(rt_out == e.rt, "R8 counter sum", {24'b0, rt_out}, {24'b0, e.rt});
        end
      end
    end
  end

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    chk(0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    step(3);
    chk(pend == 0 && !in_svc && !pc_we && !st_we && !ctx_we && !rt_we, "R11 reset state", {24'b0, pend}, 0);
    rst_n = 1;
    step(2);
    // R2: with enable low, a pending request is not taken
    set = 8'h01; step(); set = 0;
    chk(pend == 8'h01, "R1 flag set", {24'b0, pend}, 1);
    step(3);
    chk(!in_svc, "R2 gated by enable", {31'b0, in_svc}, 0);
    // first entry
    pc = 11'h123; w = 8'hA5; st = 8'hE7; fsr = 8'h3C; mode = 8'h1F;
    exp_entry(8'hE7);
    gie = 1; step(); step();
    chk(in_svc, "R2 accepted", {31'b0, in_svc}, 1);
    // inside the routine: new request, context changes, no nesting
    set = 8'h02; step(); set = 0;
    chk(pend == 8'h03, "R10 flag during service", {24'b0, pend}, 3);
    pc = 11'h2F0; w = 8'h11; st = 8'hBF; fsr = 8'h40; mode = 8'h02;
    clr = 8'h05; set = 8'h04; step(); clr = 0; set = 0;
    chk(pend == 8'h06, "R1 set beats clear", {24'b0, pend}, 6);
    step(4);
    chk(in_svc, "R6 still in service", {31'b0, in_svc}, 1);
    // plain return, then immediate re-entry for pending flags
    exp_ret(11'h123, 8'hA5, 8'hE7, 8'h3C, 8'h1F, 0, 0);
    exp_entry(8'hBF);
    ret = 1; step(); ret = 0;
    chk(!in_svc, "R7 service ends", {31'b0, in_svc}, 0);
    step();
    chk(in_svc, "R10 taken right after return", {31'b0, in_svc}, 1);
    clr = 8'h06; step(); clr = 0;
    chk(pend == 0, "R1 flags cleared", {24'b0, pend}, 0);
    // add-W return with wrap
    rtcc = 8'hF8; w = 8'h20;
    exp_ret(11'h2F0, 8'h11, 8'hBF, 8'h40, 8'h02, 1, 8'h18);
    retw = 1; step(); retw = 0;
    step(2);
    chk(!in_svc, "R8 service ends", {31'b0, in_svc}, 0);
    // R9: returns while idle are ignored
    pc = 11'h7FF; w = 8'h99; st = 8'h5A; fsr = 8'hC3; mode = 8'h81;
    ret = 1; retw = 1; step(); ret = 0; retw = 0;
    step(2);
    chk(!in_svc && !ctx_we, "R9 idle return ignored", {31'b0, in_svc}, 0);
    // later entry, then return shows only the new capture
    exp_entry(8'h5A);
    set = 8'h80; step(); set = 0; step();
    chk(in_svc, "R2 second accept", {31'b0, in_svc}, 1);
    clr = 8'h80; w = 8'h01; st = 8'h00; rtcc = 8'h10; step(); clr = 0;
    exp_ret(11'h7FF, 8'h99, 8'h5A, 8'hC3, 8'h81, 1, 8'h11);
    retw = 1; step(); retw = 0;
    step(3);
    chk(q.size() == 0, "R4 all expected loads seen", q.size(), 0);
    finish_up();
  end
endmodule